// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This unit sits between a 32-bit register datapath and a byte-addressed data memory that is one word wide. For every access it adds the base register to the sign-extended 16-bit offset. The result is a word-aligned memory address plus a lane index. On a store, the unit moves the low byte, the low halfword or the whole register into the right byte lanes and raises the matching byte enables. On a load, it takes the read word that the memory returns one cycle later, picks the addressed byte or halfword, right-justifies it, and extends it with the sign or with zeros as the request asks.

Lanes are numbered big-endian. The byte at the lowest address of a word (lane 0) sits in bits 31:24 and its enable is the most significant enable bit. An access whose address does not fit its size raises a misalignment flag for that cycle. The unit then issues no memory enable and produces no load result; the access is never split.

The requester drives `reqValid` with a direction, a size and a signedness flag. The memory sees `memAddr`, `memByteEn`, `memWe`, `memRe` and `memWdata` in the same cycle. The memory returns `memRdata` in the following cycle, and that is when `loadValid` and `loadData` come out.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is `reqBase` plus `reqOffset` sign-extended to the address width. `memAddr` is that address with its two low bits cleared, and it is driven combinationally in the request cycle.
- R2: An aligned byte access at lane k (the two low effective-address bits) sets only `memByteEn` bit 3-k, for a load or a store. On a store, `memWdata` carries `storeData[7:0]` in bits (31-8k):(24-8k) and zero in every other lane. Only `storeData` bits 7:0 are used.
- R3: An aligned halfword access at lane k (k is 0 or 2) sets `memByteEn` bits 3-k and 2-k. On a store, `storeData[15:0]` is placed in bits (31-8k):(16-8k), high byte first, and the other lanes are zero.
- R4: A word access (`reqSize` 2, or 3, which is decoded as word) at lane 0 sets all four enables. On a store, `memWdata` equals `storeData`.
- R5: A halfword access at an odd lane, or a word access at a non-zero lane, drives `misalign` high in the request cycle. In that case `memByteEn` is 0, `memWe` and `memRe` are low, `memWdata` is zero, and the next cycle has no `loadValid`.
- R6: An aligned load drives `memRe` high and `memWe` low in its request cycle, and `loadValid` high in exactly the next cycle. An aligned store drives `memWe` high and `memRe` low, leaves `memWdata` zero only in lanes it does not enable, and produces no `loadValid`.
- R7: A byte load (`reqSize` 0) returns the byte of `memRdata` at lane k in bits 7:0. With `reqUnsigned` low, bits 31:8 copy bit 7; with it high, they are zero.
- R8: A halfword load (`reqSize` 1) returns the halfword of `memRdata` starting at lane k in bits 15:0. With `reqUnsigned` low, bits 31:16 copy bit 15; with it high, they are zero.
- R9: A word load returns `memRdata` unchanged. `reqUnsigned` has no effect on word accesses or on stores.
- R10: While reset is asserted, and in any cycle without `loadValid`, `loadValid` is low and `loadData` is zero.
- R11: With `reqValid` low, `memByteEn`, `memWe`, `memRe`, `misalign` and `memWdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request this cycle |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqUnsigned | input | 1 | 1 = zero-extend sub-word loads |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| reqBase | input | ADDR_W | Base register value |
| reqOffset | input | OFFS_W | Signed displacement |
| storeData | input | DATA_W | Source register for stores |
| memAddr | output | ADDR_W | Word-aligned memory address |
| memByteEn | output | DATA_W/8 | Byte enables, MSB is lane 0 |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memWdata | output | DATA_W | Lane-placed write data |
| memRdata | input | DATA_W | Read word, one cycle after the read |
| misalign | output | 1 | Request address does not fit its size |
| loadValid | output | 1 | Load result valid |
| loadData | output | DATA_W | Extended load result |

## Verification
The bench builds the unit with its defaults: a 32-bit data word of four lanes, 32-bit addresses and 16-bit offsets. With only four lanes, every combination of lane, size code, signedness and direction can be swept completely. Each combination is driven once through a negative offset and once through a positive one. Read words mix set and clear sign bits in every lane, so both fill values of each extension are observed.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE     = 2'd0,
    ACC_HALF     = 2'd1,
    ACC_WORD     = 2'd2,
    ACC_WORD_ALT = 2'd3
  } accSize_e;

  // Strobes the control side hands to the datapath
  typedef struct packed {
    logic     storeGo;
    accSize_e reqSize;
    logic     rspGo;
    accSize_e rspSize;
    logic     rspUnsigned;
  } laneStrb_t;

  // Size code 3 is treated as a full word
  function automatic accSize_e normSize(input logic [1:0] raw);
    accSize_e s;
    case (raw)
      2'd0:    s = ACC_BYTE;
      2'd1:    s = ACC_HALF;
      default: s = ACC_WORD;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lsu_lane_ctrl.sv
module lsu_lane_ctrl
  import lsu_lane_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic                         reqStore,
  input  logic                         reqUnsigned,
  input  logic [1:0]                   reqSize,
  input  logic [$clog2(NUM_LANES)-1:0] effLow,
  output laneStrb_t                    strb,
  output logic [NUM_LANES-1:0]         laneEn,
  output logic [$clog2(NUM_LANES)-1:0] rspLane,
  output logic                         misalign,
  output logic                         memRe,
  output logic                         memWe
);

  localparam int LANE_IDX_W = $clog2(NUM_LANES);

  accSize_e sizeDec;
  logic     alignOk;
  logic     accessOk;

  assign sizeDec = normSize(reqSize);

  always_comb begin
    case (sizeDec)
      ACC_BYTE: alignOk = 1'b1;
      ACC_HALF: alignOk = (effLow[0] == 1'b0);
      default:  alignOk = (effLow == '0);
    endcase
  end

  assign accessOk = reqValid & alignOk;
  assign misalign = reqValid & ~alignOk;
  assign memWe    = accessOk & reqStore;
  assign memRe    = accessOk & ~reqStore;

  // Lane i (lane 0 = lowest address) drives enable bit NUM_LANES-1-i
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam logic [LANE_IDX_W-1:0] LANE_ID = LANE_IDX_W'(i);
    logic covered;
    always_comb begin
      case (sizeDec)
        ACC_BYTE: covered = (effLow == LANE_ID);
        ACC_HALF: covered = (effLow[LANE_IDX_W-1:1] == LANE_ID[LANE_IDX_W-1:1]);
        default:  covered = 1'b1;
      endcase
    end
    assign laneEn[NUM_LANES-1-i] = accessOk & covered;
  end

  // Response context for the read word arriving next cycle
  logic                  rspGoQ;
  logic                  rspUnsQ;
  accSize_e              rspSizeQ;
  logic [LANE_IDX_W-1:0] rspLaneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspGoQ   <= 1'b0;
      rspUnsQ  <= 1'b0;
      rspSizeQ <= ACC_WORD;
      rspLaneQ <= '0;
    end else begin
      rspGoQ <= accessOk & ~reqStore;
      if (accessOk && !reqStore) begin
        rspUnsQ  <= reqUnsigned;
        rspSizeQ <= sizeDec;
        rspLaneQ <= effLow;
      end
    end
  end

  assign rspLane          = rspLaneQ;
  assign strb.storeGo     = accessOk & reqStore;
  assign strb.reqSize     = sizeDec;
  assign strb.rspGo       = rspGoQ;
  assign strb.rspSize     = rspSizeQ;
  assign strb.rspUnsigned = rspUnsQ;

endmodule

// File: rtl/lsu_lane_datapath.sv
module lsu_lane_datapath
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16
) (
  input  logic [ADDR_W-1:0]                   reqBase,
  input  logic [OFFS_W-1:0]                   reqOffset,
  input  logic [DATA_W-1:0]                   storeData,
  input  logic [DATA_W-1:0]                   memRdata,
  input  laneStrb_t                           strb,
  input  logic [DATA_W/8-1:0]                 laneEn,
  input  logic [$clog2(DATA_W/8)-1:0]         rspLane,
  output logic [$clog2(DATA_W/8)-1:0]         effLow,
  output logic [ADDR_W-1:0]                   memAddr,
  output logic [DATA_W-1:0]                   memWdata,
  output logic                                loadValid,
  output logic [DATA_W-1:0]                   loadData
);

  localparam int NUM_LANES  = DATA_W / 8;
  localparam int LANE_IDX_W = $clog2(NUM_LANES);

  // Address generation
  logic [ADDR_W-1:0] effAddr;
  assign effAddr = reqBase + {{(ADDR_W-OFFS_W){reqOffset[OFFS_W-1]}}, reqOffset};
  assign effLow  = effAddr[LANE_IDX_W-1:0];
  assign memAddr = {effAddr[ADDR_W-1:LANE_IDX_W], {LANE_IDX_W{1'b0}}};

  // Store lane steering: each lane picks one source byte
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_wlane
    logic [7:0] laneByte;
    always_comb begin
      int srcIdx;
      case (strb.reqSize)
        ACC_BYTE: srcIdx = 0;
        ACC_HALF: srcIdx = int'(effLow) + 1 - i;
        default:  srcIdx = NUM_LANES - 1 - i;
      endcase
      laneByte = 8'h00;
      for (int j = 0; j < NUM_LANES; j++) begin
        if (j == srcIdx) laneByte = storeData[j*8 +: 8];
      end
    end
    assign memWdata[DATA_W-1-8*i -: 8] =
      (strb.storeGo && laneEn[NUM_LANES-1-i]) ? laneByte : 8'h00;
  end

  // Load lane selection and extension
  logic [7:0]        pickByte;
  logic [15:0]       pickHalf;
  logic [DATA_W-1:0] shaped;
  logic              fill;

  always_comb begin
    pickByte = 8'h00;
    pickHalf = 16'h0000;
    for (int m = 0; m < NUM_LANES; m++) begin
      if (int'(rspLane) == m) pickByte = memRdata[DATA_W-1-8*m -: 8];
    end
    for (int m = 0; m + 1 < NUM_LANES; m += 2) begin
      if (int'(rspLane) == m) pickHalf = memRdata[DATA_W-1-8*m -: 16];
    end
    case (strb.rspSize)
      ACC_BYTE: begin
        fill   = ~strb.rspUnsigned & pickByte[7];
        shaped = {{(DATA_W-8){fill}}, pickByte};
      end
      ACC_HALF: begin
        fill   = ~strb.rspUnsigned & pickHalf[15];
        shaped = {{(DATA_W-16){fill}}, pickHalf};
      end
      default: begin
        fill   = 1'b0;
        shaped = memRdata;
      end
    endcase
  end

  assign loadValid = strb.rspGo;
  assign loadData  = strb.rspGo ? shaped : '0;

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqStore,
  input  logic                reqUnsigned,
  input  logic [1:0]          reqSize,
  input  logic [ADDR_W-1:0]   reqBase,
  input  logic [OFFS_W-1:0]   reqOffset,
  input  logic [DATA_W-1:0]   storeData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic                memRe,
  output logic                memWe,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                misalign,
  output logic                loadValid,
  output logic [DATA_W-1:0]   loadData
);

  localparam int NUM_LANES  = DATA_W / 8;
  localparam int LANE_IDX_W = $clog2(NUM_LANES);

  laneStrb_t             strb;
  logic [LANE_IDX_W-1:0] effLow;
  logic [LANE_IDX_W-1:0] rspLane;

  lsu_lane_ctrl #(
    .NUM_LANES (NUM_LANES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqStore    (reqStore),
    .reqUnsigned (reqUnsigned),
    .reqSize     (reqSize),
    .effLow      (effLow),
    .strb        (strb),
    .laneEn      (memByteEn),
    .rspLane     (rspLane),
    .misalign    (misalign),
    .memRe       (memRe),
    .memWe       (memWe)
  );

  lsu_lane_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .OFFS_W (OFFS_W)
  ) u_dp (
    .reqBase   (reqBase),
    .reqOffset (reqOffset),
    .storeData (storeData),
    .memRdata  (memRdata),
    .strb      (strb),
    .laneEn    (memByteEn),
    .rspLane   (rspLane),
    .effLow    (effLow),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .loadValid (loadValid),
    .loadData  (loadData)
  );

endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqStore,
  input logic                reqUnsigned,
  input logic [1:0]          reqSize,
  input logic                misalign,
  input logic [DATA_W/8-1:0] memByteEn,
  input logic                memWe,
  input logic                memRe,
  input logic                loadValid,
  input logic [DATA_W-1:0]   loadData
);

  assert_misalign_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (memByteEn == '0) && !memWe && !memRe);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (memByteEn == '0) && !memWe && !memRe && !misalign);

  assert_byte_one_lane_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !misalign && reqSize == 2'd0) |-> $countones(memByteEn) == 1);

  assert_half_two_lanes_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !misalign && reqSize == 2'd1) |-> $countones(memByteEn) == 2);

  assert_load_response_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqStore && !misalign) |=> loadValid);

  assert_no_spurious_response_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> $past(reqValid && !reqStore && !misalign));

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  assert_ubyte_zero_fill_R7: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && $past(reqSize == 2'd0 && reqUnsigned)) |-> loadData[DATA_W-1:8] == '0);

  assert_idle_data_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |-> loadData == '0);

endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqStore    (reqStore),
  .reqUnsigned (reqUnsigned),
  .reqSize     (reqSize),
  .misalign    (misalign),
  .memByteEn   (memByteEn),
  .memWe       (memWe),
  .memRe       (memRe),
  .loadValid   (loadValid),
  .loadData    (loadData)
);

// File: tb/lsu_lane_unit_tb.sv
module lsu_lane_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqStore = 1'b0;
  logic        reqUnsigned = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [31:0] reqBase = '0;
  logic [15:0] reqOffset = '0;
  logic [31:0] storeData = '0;
  logic [31:0] memAddr;
  logic [3:0]  memByteEn;
  logic        memRe, memWe;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        misalign;
  logic        loadValid;
  logic [31:0] loadData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_lane_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqUnsigned(reqUnsigned), .reqSize(reqSize), .reqBase(reqBase),
    .reqOffset(reqOffset), .storeData(storeData), .memAddr(memAddr),
    .memByteEn(memByteEn), .memRe(memRe), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata), .misalign(misalign), .loadValid(loadValid),
    .loadData(loadData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One request, then the returned read word one cycle later
  task automatic doReq(input bit st, input bit uns, input logic [1:0] sz,
                       input logic [31:0] base, input logic [15:0] off,
                       input logic [31:0] d, input logic [31:0] w);
    logic [31:0] eff, expWd, expLd, b, h;
    logic [3:0]  expBe;
    int          kk;
    bit          mis;
    @(negedge clk);
    reqValid = 1'b1; reqStore = st; reqUnsigned = uns; reqSize = sz;
    reqBase = base; reqOffset = off; storeData = d;
    #1;
    eff = base + {{16{off[15]}}, off};
    kk  = int'(eff[1:0]);
    mis = (sz == 2'd1) ? (kk % 2 != 0) : ((sz == 2'd0) ? 1'b0 : (kk != 0));
    check("R1 memAddr", memAddr, eff & 32'hFFFF_FFFC);
    check("R5 misalign", {31'b0, misalign}, {31'b0, mis});
    if (sz == 2'd0) begin
      expBe = 4'b1000 >> kk;
      expWd = {24'b0, d[7:0]} << (24 - 8*kk);
    end else if (sz == 2'd1) begin
      expBe = 4'b1100 >> kk;
      expWd = {16'b0, d[15:0]} << (16 - 8*kk);
    end else begin
      expBe = 4'hF;
      expWd = d;
    end
    if (mis) begin
      check("R5 byte enables", {28'b0, memByteEn}, 32'h0);
      check("R5 strobes", {30'b0, memWe, memRe}, 32'h0);
      check("R5 write data", memWdata, 32'h0);
    end else begin
      check(sz == 2'd0 ? "R2 byte enables" : (sz == 2'd1 ? "R3 byte enables" : "R4 byte enables"),
            {28'b0, memByteEn}, {28'b0, expBe});
      check("R6 strobes", {30'b0, memWe, memRe}, {30'b0, st, !st});
      check(sz == 2'd0 ? "R2 write data" : (sz == 2'd1 ? "R3 write data" : "R4 write data"),
            memWdata, st ? expWd : 32'h0);
    end
    @(negedge clk);
    reqValid = 1'b0;
    memRdata = w;
    #1;
    b = (w >> (24 - 8*kk)) & 32'hFF;
    h = (w >> (16 - 8*kk)) & 32'hFFFF;
    if (sz == 2'd0)      expLd = uns ? b : {{24{b[7]}}, b[7:0]};
    else if (sz == 2'd1) expLd = uns ? h : {{16{h[15]}}, h[15:0]};
    else                 expLd = w;
    if (st || mis) begin
      check("R6 no response", {31'b0, loadValid}, 32'h0);
      check("R10 idle load data", loadData, 32'h0);
    end else begin
      check("R6 response", {31'b0, loadValid}, 32'h1);
      check(sz == 2'd0 ? "R7 byte load" : (sz == 2'd1 ? "R8 half load" : "R9 word load"),
            loadData, expLd);
    end
  endtask

  initial begin
    // R10: reset state
    #(CLK_PERIOD*2 + 1);
    check("R10 reset loadValid", {31'b0, loadValid}, 32'h0);
    check("R10 reset loadData", loadData, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    // R11: idle request lines
    @(negedge clk);
    storeData = 32'hFFFF_FFFF; reqSize = 2'd2; reqStore = 1'b1;
    #1;
    check("R11 idle enables", {28'b0, memByteEn}, 32'h0);
    check("R11 idle strobes", {29'b0, memWe, memRe, misalign}, 32'h0);
    check("R11 idle write data", memWdata, 32'h0);

    // Worked example: bytes D0 C3 at lanes 2,3 and 43 FD at lanes 0,1 of the next word
    doReq(1'b0, 1'b1, 2'd1, 32'h0000_1000, 16'd2, 32'h0, 32'h3004_D0C3);
    doReq(1'b0, 1'b0, 2'd1, 32'h0000_1000, 16'd2, 32'h0, 32'h3004_D0C3);
    doReq(1'b0, 1'b0, 2'd0, 32'h0000_1000, 16'd2, 32'h0, 32'h3004_D0C3);
    doReq(1'b0, 1'b1, 2'd1, 32'h0000_1000, 16'd4, 32'h0, 32'h43FD_1122);

    // Exhaustive sweep: direction x size code x signedness x lane x offset sign
    for (int st = 0; st < 2; st++)
      for (int sz = 0; sz < 4; sz++)
        for (int uns = 0; uns < 2; uns++)
          for (int k = 0; k < 4; k++)
            for (int pat = 0; pat < 2; pat++)
              doReq(st[0], uns[0], sz[1:0],
                    pat != 0 ? 32'h0001_2340 : 32'h8000_0010,
                    pat != 0 ? 16'(k + 4) : 16'(k - 16),
                    pat != 0 ? 32'hA5C3_7E81 : 32'h1234_F08D,
                    pat != 0 ? 32'h80FF_7F01 : 32'h7E01_8EF2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule